// File: doc/BRIEF.md
# ADC Calibration Supervisor

This block sits on the host side of an external dual-channel data converter and manages that converter's calibration. It drives the converter's calibration-request pin, picks between the full calibration sequence (resistor trim plus linearity) and the short one (linearity only), and follows the converter's calibration-busy signal through a two-flop synchronizer. The converter may also start a calibration by itself at power-up. The block treats that run the same way as one it requested.

While a calibration is pending or running, the block refuses serial-port access and output-clock reset requests. After busy drops, it holds the data-valid flag low until the converter's output pipeline has flushed. It combines the external power-down pins with the control-register power-down bits into the effective power-down lines. It raises a recalibration-needed flag when conditions make the current calibration untrustworthy: both channels off during a run, a channel coming back up, or the request pin being held high around a delay-select toggle.

Top module: `calSupervisor`

## Requirements
- R1: On each rising clock edge, `pdEffI` takes `pdPinI | pdRegI` and `pdEffQ` takes `pdPinQ | pdRegQ`, as sampled at that edge.
- R2: `spiGrant` equals `spiReq` and `dclkRstGrant` equals `dclkRstReq`, except in two cases, where both grants are 0. The first case is while the synchronized busy is 1. The second is while a calibration is requested, awaited or running.
- R3: A one-cycle `calReq` that is accepted drives `calPin` high from the next rising edge for exactly REQ_CYCLES (default 4) edges. `calReq` is ignored while busy is 1, while a calibration is requested, awaited or running, or while the pin is held by R4.
- R4: While `dlyToggle` is 1, and for HOLD_CYCLES (default 10) rising edges after it falls, `calPin` stays 1 and `recalNeeded` is set.
- R5: `seqSel` is 1 (full sequence) from reset until a full-sequence calibration has completed. After that, while idle, it follows `~shortPref` one edge later, where 0 selects the short sequence. It does not change while a calibration is requested, awaited, running or flushing.
- R6: `dataValid` is 0 from reset until a calibration completes, and it is 0 while busy is 1. After `busyIn` falls, it rises on the (SYNC_STAGES + 1 + FLUSH_CYCLES)-th rising edge, which is the 63rd with default parameters.
- R7: If both effective power-down lines are 1 while synchronized busy is 1, `recalNeeded` is 1 from the following edge.
- R8: When either effective power-down line returns from 1 to 0, `recalNeeded` is set on the edge after the line changes. Powering down a single channel outside a run does not set the flag.
- R9: `recalNeeded` clears only on the edge that registers a busy fall, and only if no set condition occurred since the preceding busy rise.
- R10: A busy rise that the converter starts by itself (no `calReq`) is tracked as a calibration: it brings the same lockout, flush delay and completion effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling-domain clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busyIn | input | 1 | Converter calibration-busy, asynchronous |
| calReq | input | 1 | One-cycle on-command calibration request |
| shortPref | input | 1 | Prefer the short sequence once a full one has run |
| dlyToggle | input | 1 | Delay-select toggle in progress; hold the request pin |
| pdPinI | input | 1 | External power-down pin, I channel |
| pdPinQ | input | 1 | External power-down pin, Q channel |
| pdRegI | input | 1 | Control-register power-down bit, I channel |
| pdRegQ | input | 1 | Control-register power-down bit, Q channel |
| spiReq | input | 1 | Serial-port transaction request |
| dclkRstReq | input | 1 | Output-clock reset request |
| calPin | output | 1 | Calibration-request pin to converter |
| seqSel | output | 1 | Sequence select: 1 full, 0 short |
| pdEffI | output | 1 | Effective power-down, I channel |
| pdEffQ | output | 1 | Effective power-down, Q channel |
| spiGrant | output | 1 | Serial-port transaction granted |
| dclkRstGrant | output | 1 | Output-clock reset granted |
| dataValid | output | 1 | Converter output data can be trusted |
| recalNeeded | output | 1 | A new calibration is required |

## Verification
The power-down combine and the grant paths are tried with a table of pin/register/request patterns while idle. These patterns separate an OR from a pass-through and show whether I and Q are crossed. A converter-initiated run, with both channels dropped mid-run, shows whether the flag survives a completion that was tainted. A later requested run shows that a clean completion clears the flag, and it measures the request pulse length, the exact flush edge and the short-sequence select. A delay-select hold with a request inside it, and a single-channel power cycle during flush, show whether the hold length is right and whether a request made during the hold is dropped.

// File: rtl/calSupPkg.sv
package calSupPkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_WAIT  = 3'd2,
    ST_RUN   = 3'd3,
    ST_FLUSH = 3'd4
  } calState_t;

  typedef struct packed {
    logic reqStart;
    logic flushStart;
    logic inIdle;
    logic inSeq;
    logic inReq;
    logic inFlush;
  } calStrobe_t;

endpackage

// File: rtl/calSupSync.sv
module calSupSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/calSupControl.sv
module calSupControl
  import calSupPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       calReq,
  input  logic       busyS,
  input  logic       busyRise,
  input  logic       busyFall,
  input  logic       holdActive,
  input  logic       reqDone,
  input  logic       flushDone,
  output calStrobe_t strobe
);
  calState_t state, stateNext;
  logic      acceptReq;

  assign acceptReq = calReq && !busyS && !holdActive;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (busyRise)       stateNext = ST_RUN;
        else if (acceptReq) stateNext = ST_REQ;
      end
      ST_REQ: begin
        if (busyRise)     stateNext = ST_RUN;
        else if (reqDone) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (busyRise) stateNext = ST_RUN;
      end
      ST_RUN: begin
        if (busyFall) stateNext = ST_FLUSH;
      end
      ST_FLUSH: begin
        if (busyRise)       stateNext = ST_RUN;
        else if (flushDone) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.reqStart   = (state == ST_IDLE) && !busyRise && acceptReq;
    strobe.flushStart = (state == ST_RUN) && busyFall;
    strobe.inIdle     = (state == ST_IDLE);
    strobe.inSeq      = (state == ST_REQ) || (state == ST_WAIT) || (state == ST_RUN);
    strobe.inReq      = (state == ST_REQ);
    strobe.inFlush    = (state == ST_FLUSH);
  end

  // R3: a request is never taken while busy or the pin is held
  a_r3_req_gated: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(state) == ST_IDLE && state == ST_REQ) |-> ($past(!busyS) && $past(!holdActive)));

  // R10: a busy rise always lands in the run state
  a_r10_rise_runs: assert property (@(posedge clk) disable iff (!rstN)
    busyRise |=> (state == ST_RUN));
endmodule

// File: rtl/calSupDatapath.sv
module calSupDatapath
  import calSupPkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int REQ_CYCLES   = 4,
  parameter int HOLD_CYCLES  = 10,
  parameter int FLUSH_CYCLES = 60
) (
  input  logic       clk,
  input  logic       rstN,
  input  calStrobe_t strobe,
  input  logic       busyIn,
  input  logic       shortPref,
  input  logic       dlyToggle,
  input  logic       pdPinI,
  input  logic       pdPinQ,
  input  logic       pdRegI,
  input  logic       pdRegQ,
  input  logic       spiReq,
  input  logic       dclkRstReq,
  output logic       busyS,
  output logic       busyRise,
  output logic       busyFall,
  output logic       holdActive,
  output logic       reqDone,
  output logic       flushDone,
  output logic       calPin,
  output logic       seqSel,
  output logic       pdEffI,
  output logic       pdEffQ,
  output logic       spiGrant,
  output logic       dclkRstGrant,
  output logic       dataValid,
  output logic       recalNeeded
);
  localparam int REQ_W   = $clog2(REQ_CYCLES + 1);
  localparam int HOLD_W  = $clog2(HOLD_CYCLES + 1);
  localparam int FLUSH_W = $clog2(FLUSH_CYCLES + 1);

  logic               busyPrev;
  logic [REQ_W-1:0]   reqCnt;
  logic [HOLD_W-1:0]  holdCnt;
  logic [FLUSH_W-1:0] flushCnt;
  logic [1:0]         pdEff, pdEffD;
  logic               calibrated, fullDone, dirty;
  logic               powerUpEv, bothDownRun, setEv, lockout;

  calSupSync #(.STAGES(SYNC_STAGES)) busySync_i (
    .clk (clk),
    .rstN(rstN),
    .d   (busyIn),
    .q   (busyS)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyPrev <= 1'b0;
    else       busyPrev <= busyS;
  end

  assign busyRise = busyS && !busyPrev;
  assign busyFall = !busyS && busyPrev;

  // request pulse length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          reqCnt <= '0;
    else if (strobe.reqStart)           reqCnt <= REQ_W'(REQ_CYCLES - 1);
    else if (strobe.inReq && reqCnt != 0) reqCnt <= reqCnt - 1'b1;
  end
  assign reqDone = strobe.inReq && (reqCnt == 0);

  // pin hold around a delay-select toggle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            holdCnt <= '0;
    else if (dlyToggle)   holdCnt <= HOLD_W'(HOLD_CYCLES);
    else if (holdCnt != 0) holdCnt <= holdCnt - 1'b1;
  end
  assign holdActive = dlyToggle || (holdCnt != 0);

  assign calPin = holdActive || strobe.inReq;

  // output pipeline flush after busy falls
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               flushCnt <= '0;
    else if (strobe.flushStart)              flushCnt <= FLUSH_W'(FLUSH_CYCLES - 1);
    else if (strobe.inFlush && flushCnt != 0) flushCnt <= flushCnt - 1'b1;
  end
  assign flushDone = strobe.inFlush && (flushCnt == 0);

  // completion tracking and sequence select
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      calibrated <= 1'b0;
      fullDone   <= 1'b0;
      seqSel     <= 1'b1;
    end else begin
      if (busyFall) begin
        calibrated <= 1'b1;
        if (seqSel) fullDone <= 1'b1;
      end
      if (strobe.inIdle) seqSel <= !fullDone || !shortPref;
    end
  end

  assign dataValid = calibrated && strobe.inIdle && !busyS;

  // effective power-down
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdEff  <= 2'b00;
      pdEffD <= 2'b00;
    end else begin
      pdEff  <= {pdPinQ | pdRegQ, pdPinI | pdRegI};
      pdEffD <= pdEff;
    end
  end
  assign pdEffI = pdEff[0];
  assign pdEffQ = pdEff[1];

  // recalibration flag
  assign powerUpEv   = |(pdEffD & ~pdEff);
  assign bothDownRun = busyS && (&pdEff);
  assign setEv       = powerUpEv || bothDownRun || holdActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirty       <= 1'b0;
      recalNeeded <= 1'b0;
    end else begin
      if (setEv)         dirty <= 1'b1;
      else if (busyRise) dirty <= 1'b0;
      if (setEv)                  recalNeeded <= 1'b1;
      else if (busyFall && !dirty) recalNeeded <= 1'b0;
    end
  end

  // serial-port and output-clock reset lockout
  assign lockout      = strobe.inSeq || busyS;
  assign spiGrant     = spiReq && !lockout;
  assign dclkRstGrant = dclkRstReq && !lockout;

  // R2: no grant of any kind while the converter reports busy
  a_r2_no_grant_busy: assert property (@(posedge clk) disable iff (!rstN)
    busyS |-> (!spiGrant && !dclkRstGrant));

  // R4: a toggle seen at the last edge keeps the pin high now
  a_r4_hold_pin: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(dlyToggle)) |-> (calPin && recalNeeded));

  // R6: no valid data while busy
  a_r6_invalid_busy: assert property (@(posedge clk) disable iff (!rstN)
    busyS |-> !dataValid);

  // R7: both channels down in a run raises the flag
  a_r7_both_down: assert property (@(posedge clk) disable iff (!rstN)
    (busyS && pdEffI && pdEffQ) |=> recalNeeded);

  // R9: the flag only clears on a registered busy fall
  a_r9_clear_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(recalNeeded) |-> $past(busyFall));

  // R5: select is frozen outside idle
  a_r5_sel_frozen: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !strobe.inIdle && $past(!strobe.inIdle)) |-> $stable(seqSel));
endmodule

// File: rtl/calSupervisor.sv
module calSupervisor
  import calSupPkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int REQ_CYCLES   = 4,
  parameter int HOLD_CYCLES  = 10,
  parameter int FLUSH_CYCLES = 60
) (
  input  logic clk,
  input  logic rstN,
  input  logic busyIn,
  input  logic calReq,
  input  logic shortPref,
  input  logic dlyToggle,
  input  logic pdPinI,
  input  logic pdPinQ,
  input  logic pdRegI,
  input  logic pdRegQ,
  input  logic spiReq,
  input  logic dclkRstReq,
  output logic calPin,
  output logic seqSel,
  output logic pdEffI,
  output logic pdEffQ,
  output logic spiGrant,
  output logic dclkRstGrant,
  output logic dataValid,
  output logic recalNeeded
);
  calStrobe_t strobe;
  logic busyS, busyRise, busyFall, holdActive, reqDone, flushDone;

  calSupControl control_i (
    .clk       (clk),
    .rstN      (rstN),
    .calReq    (calReq),
    .busyS     (busyS),
    .busyRise  (busyRise),
    .busyFall  (busyFall),
    .holdActive(holdActive),
    .reqDone   (reqDone),
    .flushDone (flushDone),
    .strobe    (strobe)
  );

  calSupDatapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .REQ_CYCLES  (REQ_CYCLES),
    .HOLD_CYCLES (HOLD_CYCLES),
    .FLUSH_CYCLES(FLUSH_CYCLES)
  ) datapath_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .busyIn      (busyIn),
    .shortPref   (shortPref),
    .dlyToggle   (dlyToggle),
    .pdPinI      (pdPinI),
    .pdPinQ      (pdPinQ),
    .pdRegI      (pdRegI),
    .pdRegQ      (pdRegQ),
    .spiReq      (spiReq),
    .dclkRstReq  (dclkRstReq),
    .busyS       (busyS),
    .busyRise    (busyRise),
    .busyFall    (busyFall),
    .holdActive  (holdActive),
    .reqDone     (reqDone),
    .flushDone   (flushDone),
    .calPin      (calPin),
    .seqSel      (seqSel),
    .pdEffI      (pdEffI),
    .pdEffQ      (pdEffQ),
    .spiGrant    (spiGrant),
    .dclkRstGrant(dclkRstGrant),
    .dataValid   (dataValid),
    .recalNeeded (recalNeeded)
  );

  // R1: effective power-down follows the OR of pin and register bit
  a_r1_pd_or: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((pdEffI == $past(pdPinI | pdRegI)) && (pdEffQ == $past(pdPinQ | pdRegQ))));
endmodule

// File: tb/calSupervisor_tb_top.sv
module calSupervisor_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busyIn = 0, calReq = 0, shortPref = 0, dlyToggle = 0;
  logic pdPinI = 0, pdPinQ = 0, pdRegI = 0, pdRegQ = 0;
  logic spiReq = 0, dclkRstReq = 0;
  logic calPin, seqSel, pdEffI, pdEffQ, spiGrant, dclkRstGrant, dataValid, recalNeeded;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  calSupervisor dut_i (
    .clk(clk), .rstN(rstN), .busyIn(busyIn), .calReq(calReq), .shortPref(shortPref),
    .dlyToggle(dlyToggle), .pdPinI(pdPinI), .pdPinQ(pdPinQ), .pdRegI(pdRegI), .pdRegQ(pdRegQ),
    .spiReq(spiReq), .dclkRstReq(dclkRstReq), .calPin(calPin), .seqSel(seqSel),
    .pdEffI(pdEffI), .pdEffQ(pdEffQ), .spiGrant(spiGrant), .dclkRstGrant(dclkRstGrant),
    .dataValid(dataValid), .recalNeeded(recalNeeded)
  );

  // {pinI,pinQ,regI,regQ,spiReq,dclkReq, expEffI,expEffQ,expSpi,expDclk}
  localparam logic [9:0] VECS [8] = '{
    10'b0000_00_00_00,
    10'b1000_10_10_10,
    10'b0100_01_01_01,
    10'b0010_11_10_11,
    10'b0001_00_01_00,
    10'b1001_10_11_10,
    10'b0110_01_11_01,
    10'b1111_11_11_11
  };

  task automatic check(input logic act, input logic exp, input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    busyIn = 0; calReq = 0; shortPref = 0; dlyToggle = 0;
    pdPinI = 0; pdPinQ = 0; pdRegI = 0; pdRegQ = 0; spiReq = 0; dclkRstReq = 0;
    step(3);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    doReset();
    // reset state
    check(calPin, 1'b0, "reset calPin R3");
    check(seqSel, 1'b1, "reset seqSel R5");
    check(dataValid, 1'b0, "reset dataValid R6");
    check(recalNeeded, 1'b0, "reset recalNeeded R9");

    // table: power-down combine (R1) and idle grants (R2)
    for (int v = 0; v < 8; v++) begin
      {pdPinI, pdPinQ, pdRegI, pdRegQ, spiReq, dclkRstReq} = VECS[v][9:4];
      step(1);
      check(pdEffI, VECS[v][3], "vector pdEffI R1");
      check(pdEffQ, VECS[v][2], "vector pdEffQ R1");
      check(spiGrant, VECS[v][1], "vector spiGrant R2");
      check(dclkRstGrant, VECS[v][0], "vector dclkRstGrant R2");
    end

    doReset();
    // converter-initiated calibration (R10) with both channels dropped (R7)
    shortPref = 1; busyIn = 1; spiReq = 1; dclkRstReq = 1;
    step(1);
    check(spiGrant, 1'b1, "grant before sync R2");
    step(1);
    check(spiGrant, 1'b0, "spi lock on busy R2");
    check(dclkRstGrant, 1'b0, "dclk lock on busy R2");
    check(seqSel, 1'b1, "first run full R5");
    step(1);
    pdPinI = 1; pdRegQ = 1;
    step(1);
    check(recalNeeded, 1'b0, "flag before both-down edge R7");
    step(1);
    check(recalNeeded, 1'b1, "both down in run R7");
    pdPinI = 0; pdRegQ = 0;
    step(3);
    busyIn = 0;
    step(2);
    check(spiGrant, 1'b0, "run lockout after sync fall R2");
    step(1);
    check(spiGrant, 1'b1, "grant in flush R10");
    check(recalNeeded, 1'b1, "tainted run keeps flag R9");
    step(59);
    check(dataValid, 1'b0, "valid at edge 62 R6");
    check(seqSel, 1'b1, "sel held through flush R5");
    step(1);
    check(dataValid, 1'b1, "valid at edge 63 R6");
    step(1);
    check(seqSel, 1'b0, "short after full R5");

    // requested calibration
    calReq = 1;
    step(1);
    calReq = 0;
    check(calPin, 1'b1, "pin on accept R3");
    check(dataValid, 1'b0, "invalid once requested R6");
    step(3);
    check(calPin, 1'b1, "pin at edge 4 R3");
    step(1);
    check(calPin, 1'b0, "pin low at edge 5 R3");
    check(spiGrant, 1'b0, "lock while awaiting R2");
    calReq = 1;
    step(1);
    calReq = 0;
    step(5);
    check(calPin, 1'b0, "request ignored while awaiting R3");
    busyIn = 1;
    step(3);
    busyIn = 0;
    step(2);
    check(recalNeeded, 1'b1, "flag before clean fall R9");
    step(1);
    check(recalNeeded, 1'b0, "clean run clears flag R9");
    // single-channel power cycle in flush (R8)
    pdRegI = 1;
    step(2);
    check(recalNeeded, 1'b0, "single down no flag R8");
    pdRegI = 0;
    step(1);
    check(recalNeeded, 1'b0, "flag one edge after up R8");
    step(1);
    check(recalNeeded, 1'b1, "power-up sets flag R8");
    step(57);
    check(dataValid, 1'b1, "valid after second flush R6");

    // delay-select hold (R4) with request inside it (R3)
    dlyToggle = 1;
    step(1);
    check(calPin, 1'b1, "hold pin high R4");
    check(recalNeeded, 1'b1, "hold sets flag R4");
    step(1);
    calReq = 1;
    step(1);
    calReq = 0; dlyToggle = 0;
    step(9);
    check(calPin, 1'b1, "pin high 9 edges after R4");
    step(1);
    check(calPin, 1'b0, "pin low 10 edges after R4");
    step(5);
    check(calPin, 1'b0, "request during hold dropped R3");
    check(spiGrant, 1'b1, "no sequence after hold R3");

    finish();
  end

  initial begin
    #2000000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end
endmodule